// File: doc/BRIEF.md
# Transaction Aging Priority Escalator

This block sits next to a bus master and sets the 2-bit priority that the master presents to the system bus arbiter. While one of the master's transactions is outstanding, an age counter advances by one on each bus clock. Once the age reaches a programmable threshold, the requested priority moves from a programmed base level to a programmed aged level. It stays there until the transaction completes.

Software programs the two levels, an enable bit and the threshold through a small word-addressed register port. The master reports each transaction with a start strobe and a completion strobe. With the enable bit clear, the output holds the base level whatever the age. A common setting is base level 0, aged level 3 and a threshold of 40 cycles.

Top module: `txn_age_escalator`

## Requirements
- R1: During reset and on the first cycle after it, `bus_prio` is 0 and `age_state` is 0. Both configuration registers read as zero, so the enable bit is clear.
- R2: Word address 0 is the priority control register. Bits [1:0] hold the base level, bits [3:2] hold the aged level and bit 4 is the enable. Address 1 holds the threshold in bits [13:0]. All other bits of both registers read zero and ignore writes.
- R3: A start strobe sampled at edge S, with no transaction pending, begins a transaction with age 0. The age increases by one at every later edge until the transaction completes. `age_state` becomes 1 at edge S+T+1, where T is the threshold, and stays 0 before that edge.
- R4: When `age_state` is 0, `bus_prio` equals the base level. When `age_state` is 1, it equals the aged level. Both outputs are registered from the configuration of the previous cycle.
- R5: While the enable bit is clear, `age_state` stays 0 and `bus_prio` stays at the base level, whatever the age.
- R6: A completion strobe sampled at edge D clears the age and the pending flag. From edge D+1, `age_state` is 0 and `bus_prio` is the base level.
- R7: The age saturates at its all-ones value (16383) instead of wrapping. A transaction that stalls that long keeps the aged level.
- R8: A write that lowers the threshold below the current age, made during a transaction, switches `age_state` to 1 at the edge after the write edge.
- R9: A start strobe while a transaction is pending does not restart the age. A start and a completion in the same cycle end the current transaction and begin a new one at age 0.
- R10: A write to the level fields takes effect on `bus_prio` at the edge after the write edge.
- R11: Writes to addresses 2 and 3 change no register, and those addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| txn_start | input | 1 | Transaction start strobe |
| txn_done | input | 1 | Transaction completion strobe |
| bus_prio | output | 2 | Priority level requested from the arbiter |
| age_state | output | 1 | Current priority state: 0 base, 1 aged |

## Verification
The bench samples the threshold crossing on the exact cycle before and after it. An off-by-one compare or an unregistered state therefore shows up as the aged level arriving one cycle early or late. A threshold of zero and a run of more than 16383 cycles test the two ends of the compare. A counter that wraps would fall back to the base level after 16384 cycles. Other cases cover a second start during a transaction (a design that restarts the age would stay low too long), a start coinciding with completion (a design that lets the completion win would lose the new transaction), a threshold lowered mid-transaction, a mid-transaction level change, and writes to reserved bits and unmapped addresses.

// File: rtl/txn_age_pkg.sv
package txn_age_pkg;

    localparam int DATA_W = 32;
    localparam int THR_W  = 14;
    localparam int LVL_W  = 2;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_THR  = 2'd1;

    // Control register layout: enable above aged level above base level
    typedef struct packed {
        logic             en;
        logic [LVL_W-1:0] hi;
        logic [LVL_W-1:0] lo;
    } prio_cfg_t;

    localparam int CFG_W = $bits(prio_cfg_t);

    typedef enum logic {
        ST_BASE = 1'b0,
        ST_AGED = 1'b1
    } age_state_e;

    function automatic logic [THR_W-1:0] sat_inc(input logic [THR_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/txn_age_regs.sv
module txn_age_regs
    import txn_age_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int TW = THR_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output prio_cfg_t     cfg,
    output logic [TW-1:0] thr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
            thr <= '0;
        end else if (we) begin
            case (addr)
                ADDR_CTRL: cfg <= prio_cfg_t'(wdata[CFG_W-1:0]);
                ADDR_THR:  thr <= wdata[TW-1:0];
                default:   ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_CTRL: rdata[CFG_W-1:0] = cfg;
            ADDR_THR:  rdata[TW-1:0]    = thr;
            default:   ;
        endcase
    end

endmodule

// File: rtl/txn_age_tracker.sv
module txn_age_tracker
    import txn_age_pkg::*;
#(
    parameter int TW = THR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          done,
    output logic          pending,
    output logic [TW-1:0] age
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            age     <= '0;
        end else if (done) begin
            // completion ends the current one; a coincident start opens the next
            pending <= start;
            age     <= '0;
        end else if (pending) begin
            age <= sat_inc(age);
        end else begin
            pending <= start;
            age     <= '0;
        end
    end

endmodule

// File: rtl/txn_age_select.sv
module txn_age_select
    import txn_age_pkg::*;
#(
    parameter int TW = THR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pending,
    input  logic [TW-1:0]    age,
    input  logic [TW-1:0]    thr,
    input  prio_cfg_t        cfg,
    output age_state_e       state_q,
    output logic [LVL_W-1:0] prio_q
);

    age_state_e state_d;

    always_comb begin
        state_d = (cfg.en && pending && (age >= thr)) ? ST_AGED : ST_BASE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_BASE;
            prio_q  <= '0;
        end else begin
            state_q <= state_d;
            prio_q  <= (state_d == ST_AGED) ? cfg.hi : cfg.lo;
        end
    end

endmodule

// File: rtl/txn_age_escalator.sv
module txn_age_escalator
    import txn_age_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int TW = THR_W,
    parameter int AW = ADDR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [DW-1:0]    cfg_wdata,
    output logic [DW-1:0]    cfg_rdata,
    input  logic             txn_start,
    input  logic             txn_done,
    output logic [LVL_W-1:0] bus_prio,
    output logic             age_state
);

    prio_cfg_t     cfg_q;
    logic [TW-1:0] thr_q;
    logic          pending;
    logic [TW-1:0] age;
    age_state_e    state_q;

    txn_age_regs #(.DW(DW), .TW(TW), .AW(AW)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg_q),
        .thr   (thr_q)
    );

    txn_age_tracker #(.TW(TW)) u_track (
        .clk     (clk),
        .rst     (rst),
        .start   (txn_start),
        .done    (txn_done),
        .pending (pending),
        .age     (age)
    );

    txn_age_select #(.TW(TW)) u_sel (
        .clk     (clk),
        .rst     (rst),
        .pending (pending),
        .age     (age),
        .thr     (thr_q),
        .cfg     (cfg_q),
        .state_q (state_q),
        .prio_q  (bus_prio)
    );

    assign age_state = (state_q == ST_AGED);

endmodule

// File: rtl/txn_age_chk.sv
module txn_age_chk
    import txn_age_pkg::*;
#(
    parameter int TW = THR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             txn_start,
    input  logic             txn_done,
    input  logic [LVL_W-1:0] bus_prio,
    input  logic             age_state,
    input  prio_cfg_t        cfg_q,
    input  logic             pending,
    input  logic [TW-1:0]    age
);

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (bus_prio == '0 && !age_state)); // R1

    AST_PRIO_AGED: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && age_state) |-> (bus_prio == $past(cfg_q.hi))); // R4

    AST_PRIO_BASE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !age_state) |-> (bus_prio == $past(cfg_q.lo))); // R4

    AST_DISABLED_BASE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cfg_q.en)) |-> !age_state); // R5

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (txn_done && !txn_start) |-> ##2 !age_state); // R6

    AST_AGE_STEP: assert property (@(posedge clk) disable iff (rst)
        (pending && !txn_done && !(&age)) |=> (age == $past(age) + 1'b1)); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (pending && !txn_done && (&age)) |=> (&age)); // R7

endmodule

bind txn_age_escalator txn_age_chk #(.TW(TW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .txn_start (txn_start),
    .txn_done  (txn_done),
    .bus_prio  (bus_prio),
    .age_state (age_state),
    .cfg_q     (cfg_q),
    .pending   (pending),
    .age       (age)
);

// File: tb/txn_age_escalator_tb.sv
module txn_age_escalator_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        txn_start = 1'b0;
    logic        txn_done = 1'b0;
    logic [1:0]  bus_prio;
    logic        age_state;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    txn_age_escalator dut_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .txn_start (txn_start),
        .txn_done  (txn_done),
        .bus_prio  (bus_prio),
        .age_state (age_state)
    );

    typedef struct packed {
        logic [1:0]  lo;
        logic [1:0]  hi;
        logic        en;
        logic [13:0] thr;
        logic [15:0] hold;
        logic [1:0]  exp_prio;
        logic        exp_state;
    } vec_t;

    // R3/R4/R5: start at edge S, sample after edge S+hold
    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd3, 1'b1, 14'd40, 16'd39,  2'd0, 1'b0},
        '{2'd0, 2'd3, 1'b1, 14'd40, 16'd40,  2'd0, 1'b0},
        '{2'd0, 2'd3, 1'b1, 14'd40, 16'd41,  2'd3, 1'b1},
        '{2'd0, 2'd3, 1'b1, 14'd40, 16'd100, 2'd3, 1'b1},
        '{2'd0, 2'd3, 1'b0, 14'd40, 16'd100, 2'd0, 1'b0},
        '{2'd1, 2'd2, 1'b0, 14'd5,  16'd50,  2'd1, 1'b0},
        '{2'd1, 2'd2, 1'b1, 14'd5,  16'd5,   2'd1, 1'b0},
        '{2'd1, 2'd2, 1'b1, 14'd5,  16'd6,   2'd2, 1'b1},
        '{2'd2, 2'd1, 1'b1, 14'd0,  16'd0,   2'd2, 1'b0},
        '{2'd2, 2'd1, 1'b1, 14'd0,  16'd1,   2'd1, 1'b1},
        '{2'd3, 2'd3, 1'b1, 14'd1,  16'd2,   2'd3, 1'b1}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic cfg_read(input logic [1:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic set_cfg(input logic [1:0] lo, input logic [1:0] hi, input logic en,
                           input logic [13:0] thr);
        cfg_write(2'd0, {27'd0, en, hi, lo});
        cfg_write(2'd1, {18'd0, thr});
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_start();
        txn_start = 1'b1; @(negedge clk); txn_start = 1'b0;
    endtask

    task automatic pulse_done();
        txn_done = 1'b1; @(negedge clk); txn_done = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        check("R1 prio in reset", {30'd0, bus_prio}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 prio after reset", {30'd0, bus_prio}, 32'd0);
        check("R1 state after reset", {31'd0, age_state}, 32'd0);
        cfg_read(2'd0, rd); check("R1 ctrl reset", rd, 32'd0);
        cfg_read(2'd1, rd); check("R1 thr reset", rd, 32'd0);

        // R2 reserved bits
        cfg_write(2'd0, 32'hFFFF_FFFF);
        cfg_read(2'd0, rd); check("R2 ctrl reserved", rd, 32'h0000_001F);
        cfg_write(2'd1, 32'hFFFF_FFFF);
        cfg_read(2'd1, rd); check("R2 thr reserved", rd, 32'h0000_3FFF);
        cfg_write(2'd0, 32'h0000_0009);
        cfg_read(2'd0, rd); check("R2 ctrl fields", rd, 32'h0000_0009);

        // R11 unmapped addresses
        cfg_write(2'd2, 32'hFFFF_FFFF);
        cfg_write(2'd3, 32'hFFFF_FFFF);
        cfg_read(2'd2, rd); check("R11 addr2 read", rd, 32'd0);
        cfg_read(2'd3, rd); check("R11 addr3 read", rd, 32'd0);
        cfg_read(2'd0, rd); check("R11 ctrl untouched", rd, 32'h0000_0009);
        cfg_read(2'd1, rd); check("R11 thr untouched", rd, 32'h0000_3FFF);

        // table walk
        for (int i = 0; i < NV; i++) begin
            set_cfg(VECS[i].lo, VECS[i].hi, VECS[i].en, VECS[i].thr);
            pulse_start();
            repeat (int'(VECS[i].hold)) @(negedge clk);
            check($sformatf("R3/R4/R5 vec%0d prio", i), {30'd0, bus_prio}, {30'd0, VECS[i].exp_prio});
            check($sformatf("R3/R5 vec%0d state", i), {31'd0, age_state}, {31'd0, VECS[i].exp_state});
            pulse_done();
            repeat (3) @(negedge clk);
        end

        set_cfg(2'd0, 2'd3, 1'b1, 14'd40);

        // R9 second start ignored, then start coinciding with done
        pulse_start();
        repeat (29) @(negedge clk);
        pulse_start();
        repeat (11) @(negedge clk);
        check("R9 restart ignored", {30'd0, bus_prio}, 32'd3);
        txn_start = 1'b1; txn_done = 1'b1;
        @(negedge clk);
        txn_start = 1'b0; txn_done = 1'b0;
        repeat (40) @(negedge clk);
        check("R9 new txn below thr", {30'd0, bus_prio}, 32'd0);
        @(negedge clk);
        check("R9 new txn aged", {30'd0, bus_prio}, 32'd3);
        pulse_done();
        repeat (3) @(negedge clk);

        // R6 completion clears
        pulse_start();
        repeat (50) @(negedge clk);
        check("R6 aged before done", {30'd0, bus_prio}, 32'd3);
        pulse_done();
        check("R6 at done edge", {30'd0, bus_prio}, 32'd3);
        @(negedge clk);
        check("R6 prio after done", {30'd0, bus_prio}, 32'd0);
        check("R6 state after done", {31'd0, age_state}, 32'd0);
        repeat (3) @(negedge clk);

        // R8 threshold lowered below current age
        pulse_start();
        repeat (20) @(negedge clk);
        cfg_write(2'd1, 32'd10);
        check("R8 write edge", {30'd0, bus_prio}, 32'd0);
        @(negedge clk);
        check("R8 next edge", {30'd0, bus_prio}, 32'd3);
        pulse_done();
        repeat (3) @(negedge clk);
        set_cfg(2'd0, 2'd3, 1'b1, 14'd40);

        // R10 level change, R5 disable mid-transaction
        pulse_start();
        repeat (45) @(negedge clk);
        cfg_write(2'd0, {27'd0, 1'b1, 2'd1, 2'd0});
        check("R10 write edge", {30'd0, bus_prio}, 32'd3);
        @(negedge clk);
        check("R10 new aged level", {30'd0, bus_prio}, 32'd1);
        cfg_write(2'd0, {27'd0, 1'b0, 2'd1, 2'd2});
        @(negedge clk);
        check("R5 disable mid txn prio", {30'd0, bus_prio}, 32'd2);
        check("R5 disable mid txn state", {31'd0, age_state}, 32'd0);
        pulse_done();
        repeat (3) @(negedge clk);

        // R7 saturation
        set_cfg(2'd0, 2'd3, 1'b1, 14'd16383);
        pulse_start();
        repeat (16383) @(negedge clk);
        check("R7 at max thr", {30'd0, bus_prio}, 32'd0);
        @(negedge clk);
        check("R7 aged at max", {30'd0, bus_prio}, 32'd3);
        repeat (100) @(negedge clk);
        check("R7 no wrap", {30'd0, bus_prio}, 32'd3);
        pulse_done();
        repeat (3) @(negedge clk);
        check("R6 idle at end", {30'd0, bus_prio}, 32'd0);

        finish_run();
    end

endmodule